// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory with two independent access ports (left and right). It watches each port's address, active-low enable and active-low write strobe. When both ports are enabled on the same location it picks one port to stall. That port receives an active-low busy indication, and its write is withheld from the memory. The block passes the qualified write strobes on to the memory, so a stalled port can never corrupt the location the other port is using.

Arrival order is tracked in clock cycles. Each cycle the block notes which port's address or enable changed. On a collision, the port that changed most recently loses. If both ports change in the same cycle, the tie goes to the left port and the right port is stalled.

A configuration input selects the mode. In master mode the block drives its two busy outputs itself. In slave mode a neighbouring master's busy lines arrive on the busy inputs. Those inputs only gate this block's writes, and the block's own busy outputs stay high.

Top module: `dualPortCollisionArbiter`

## Requirements
- R1: In master mode both busy outputs remain high unless, in the previous cycle, both enables were low and the two addresses were equal.
- R2: On a collision, the port whose address or enable changed in a later cycle than the other port's receives busy low from the next cycle on. The other port's busy stays high.
- R3: If both ports change in the same cycle and thereby collide, the right busy output goes low and the left stays high.
- R4: The two busy outputs are never low in the same cycle.
- R5: In master mode, the losing port's qualified write stays high in the cycle the collision first appears and in every cycle its busy output is low. The winning port's write passes.
- R6: In slave mode both busy outputs stay high. A low level on a port's busy input holds that port's qualified write high.
- R7: Once the match ends (address differs or either enable goes high), the busy output is released at the next clock edge.
- R8: A qualified write is low only when the port's enable is low, its write strobe is low and the port is not blocked.
- R9: After reset both busy outputs are high, and an earlier tie or change history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | 1 = drive busy outputs, 0 = accept busy inputs |
| leftAddr | input | 14 | Left port address |
| leftCeN | input | 1 | Left port enable, active low |
| leftWrN | input | 1 | Left port write strobe, active low |
| rightAddr | input | 14 | Right port address |
| rightCeN | input | 1 | Right port enable, active low |
| rightWrN | input | 1 | Right port write strobe, active low |
| leftBusyInN | input | 1 | Busy from a master, left port (slave mode) |
| rightBusyInN | input | 1 | Busy from a master, right port (slave mode) |
| leftBusyOutN | output | 1 | Left busy, active low (master mode) |
| rightBusyOutN | output | 1 | Right busy, active low (master mode) |
| leftMemWrN | output | 1 | Qualified left write to the memory |
| rightMemWrN | output | 1 | Qualified right write to the memory |

## Verification
Two functions can fall in the same cycle. One is the arrival of a new address that creates a collision. The other is a write strobe issued by that same port. The write must be blocked before the registered busy output has even fallen. The bench provokes this by moving one port onto the other's address with its write strobe already low. It checks the qualified write a moment later in the same cycle, then checks the busy outputs after the next edge. The same-cycle tie and the release cycle are probed in the same way, by sampling both before and after the edge that should change them.

// File: rtl/collArbPkg.sv
package collArbPkg;

  typedef enum logic {
    LATER_LEFT  = 1'b0,
    LATER_RIGHT = 1'b1
  } laterPort_e;

  // observations from the datapath towards the control
  typedef struct packed {
    logic match;
    logic leftMoved;
    logic rightMoved;
  } arbObs_t;

  // strobes from the control towards the datapath
  typedef struct packed {
    logic leftLoseNow;
    logic rightLoseNow;
    logic leftBusyHeld;
    logic rightBusyHeld;
  } arbStrobe_t;

endpackage

// File: rtl/collArbDatapath.sv
module collArbDatapath
  import collArbPkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftCeN,
  input  logic              leftWrN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightCeN,
  input  logic              rightWrN,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  input  arbStrobe_t        strobe,
  output arbObs_t           obs,
  output logic              leftMemWrN,
  output logic              rightMemWrN
);

  localparam int NUM_PORTS = 2;

  logic [ADDR_W-1:0] addrIn [NUM_PORTS];
  logic              ceNIn  [NUM_PORTS];
  logic              moved  [NUM_PORTS];

  assign addrIn[0] = leftAddr;
  assign addrIn[1] = rightAddr;
  assign ceNIn[0]  = leftCeN;
  assign ceNIn[1]  = rightCeN;

  // per-port settle tracking: remember last cycle's inputs, flag any change
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [ADDR_W-1:0] addrQ;
    logic              ceNQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ <= '0;
        ceNQ  <= 1'b1;
      end else begin
        addrQ <= addrIn[p];
        ceNQ  <= ceNIn[p];
      end
    end

    assign moved[p] = (addrQ != addrIn[p]) || (ceNQ != ceNIn[p]);
  end

  assign obs.match      = !leftCeN && !rightCeN && (leftAddr == rightAddr);
  assign obs.leftMoved  = moved[0];
  assign obs.rightMoved = moved[1];

  logic leftBlock;
  logic rightBlock;

  always_comb begin
    if (masterMode) begin
      leftBlock  = strobe.leftLoseNow  || strobe.leftBusyHeld;
      rightBlock = strobe.rightLoseNow || strobe.rightBusyHeld;
    end else begin
      leftBlock  = !leftBusyInN;
      rightBlock = !rightBusyInN;
    end
  end

  assign leftMemWrN  = leftWrN  || leftCeN  || leftBlock;
  assign rightMemWrN = rightWrN || rightCeN || rightBlock;

  // R5: a held busy in master mode keeps the write away from the memory
  assert_write_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && strobe.leftBusyHeld) |-> leftMemWrN);
  assert_write_blocked_right_R5: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && strobe.rightBusyHeld) |-> rightMemWrN);
  // R6: in slave mode the busy input alone gates the write
  assert_slave_inhibit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && (!leftBusyInN || leftCeN)) |-> leftMemWrN);

endmodule

// File: rtl/collArbControl.sv
module collArbControl
  import collArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterMode,
  input  arbObs_t    obs,
  output arbStrobe_t strobe,
  output logic       leftBusyOutN,
  output logic       rightBusyOutN
);

  laterPort_e laterQ;
  laterPort_e laterD;
  logic       leftHeldQ;
  logic       rightHeldQ;

  // which port settled last; a same-cycle change counts against the right port
  always_comb begin
    if (obs.leftMoved && !obs.rightMoved)      laterD = LATER_LEFT;
    else if (obs.rightMoved)                   laterD = LATER_RIGHT;
    else                                       laterD = laterQ;
  end

  assign strobe.leftLoseNow   = obs.match && (laterD == LATER_LEFT);
  assign strobe.rightLoseNow  = obs.match && (laterD == LATER_RIGHT);
  assign strobe.leftBusyHeld  = leftHeldQ;
  assign strobe.rightBusyHeld = rightHeldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laterQ     <= LATER_RIGHT;
      leftHeldQ  <= 1'b0;
      rightHeldQ <= 1'b0;
    end else begin
      laterQ     <= laterD;
      leftHeldQ  <= strobe.leftLoseNow;
      rightHeldQ <= strobe.rightLoseNow;
    end
  end

  assign leftBusyOutN  = !(masterMode && leftHeldQ);
  assign rightBusyOutN = !(masterMode && rightHeldQ);

  // R4: never both busy
  assert_busy_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(!leftBusyOutN && !rightBusyOutN));
  // R1: a held busy always follows a matching cycle
  assert_busy_needs_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    (leftHeldQ || rightHeldQ) |-> $past(obs.match));
  // R3: simultaneous change onto a shared address stalls the right port
  assert_tie_right_R3: assert property (@(posedge clk) disable iff (!rstN)
    (obs.match && obs.leftMoved && obs.rightMoved) |=> (rightHeldQ && !leftHeldQ));
  // R7: no match this cycle means no busy next cycle
  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !obs.match |=> (!leftHeldQ && !rightHeldQ));
  // R6: slave mode leaves both busy outputs inactive
  assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (leftBusyOutN && rightBusyOutN));

endmodule

// File: rtl/dualPortCollisionArbiter.sv
module dualPortCollisionArbiter
  import collArbPkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftCeN,
  input  logic              leftWrN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightCeN,
  input  logic              rightWrN,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftMemWrN,
  output logic              rightMemWrN
);

  arbObs_t    obs;
  arbStrobe_t strobe;

  collArbDatapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .masterMode   (masterMode),
    .leftAddr     (leftAddr),
    .leftCeN      (leftCeN),
    .leftWrN      (leftWrN),
    .rightAddr    (rightAddr),
    .rightCeN     (rightCeN),
    .rightWrN     (rightWrN),
    .leftBusyInN  (leftBusyInN),
    .rightBusyInN (rightBusyInN),
    .strobe       (strobe),
    .obs          (obs),
    .leftMemWrN   (leftMemWrN),
    .rightMemWrN  (rightMemWrN)
  );

  collArbControl u_control (
    .clk           (clk),
    .rstN          (rstN),
    .masterMode    (masterMode),
    .obs           (obs),
    .strobe        (strobe),
    .leftBusyOutN  (leftBusyOutN),
    .rightBusyOutN (rightBusyOutN)
  );

endmodule

// File: tb/dualPortCollisionArbiter_tb.sv
module dualPortCollisionArbiter_tb;

  localparam int ADDR_W = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              masterMode = 1'b1;
  logic [ADDR_W-1:0] leftAddr = '0;
  logic              leftCeN = 1'b1;
  logic              leftWrN = 1'b1;
  logic [ADDR_W-1:0] rightAddr = '0;
  logic              rightCeN = 1'b1;
  logic              rightWrN = 1'b1;
  logic              leftBusyInN = 1'b1;
  logic              rightBusyInN = 1'b1;
  logic              leftBusyOutN;
  logic              rightBusyOutN;
  logic              leftMemWrN;
  logic              rightMemWrN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dualPortCollisionArbiter #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftAddr(leftAddr), .leftCeN(leftCeN), .leftWrN(leftWrN),
    .rightAddr(rightAddr), .rightCeN(rightCeN), .rightWrN(rightWrN),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN),
    .leftMemWrN(leftMemWrN), .rightMemWrN(rightMemWrN)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // advance one edge; inputs are then driven 5 ns after it
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    leftCeN = 1'b1; rightCeN = 1'b1; leftWrN = 1'b1; rightWrN = 1'b1;
    leftBusyInN = 1'b1; rightBusyInN = 1'b1;
    tick(); tick();
  endtask

  task automatic testReset();
    check("R9", "leftBusy after reset", leftBusyOutN, 1'b1);
    check("R9", "rightBusy after reset", rightBusyOutN, 1'b1);
    check("R8", "leftWr idle", leftMemWrN, 1'b1);
  endtask

  task automatic testNoMatch();
    leftCeN = 0; rightCeN = 0; leftAddr = 14'h0123; rightAddr = 14'h0124;
    leftWrN = 0; rightWrN = 0;
    #1;
    check("R8", "left write passes", leftMemWrN, 1'b0);
    check("R8", "right write passes", rightMemWrN, 1'b0);
    tick();
    check("R1", "leftBusy distinct addr", leftBusyOutN, 1'b1);
    check("R1", "rightBusy distinct addr", rightBusyOutN, 1'b1);
    // same address but left disabled: still no busy
    leftCeN = 1; rightAddr = 14'h0123;
    tick(); tick();
    check("R1", "leftBusy with enable high", leftBusyOutN, 1'b1);
    check("R1", "rightBusy with enable high", rightBusyOutN, 1'b1);
    idle();
  endtask

  task automatic testRightLater();
    leftCeN = 0; rightCeN = 0; leftAddr = 14'h0005; rightAddr = 14'h0009;
    tick();
    rightAddr = 14'h0005; leftWrN = 0; rightWrN = 0;
    #1;
    check("R5", "right write blocked same cycle", rightMemWrN, 1'b1);
    check("R5", "left write passes on collision", leftMemWrN, 1'b0);
    tick();
    check("R2", "rightBusy low (right later)", rightBusyOutN, 1'b0);
    check("R2", "leftBusy high (left earlier)", leftBusyOutN, 1'b1);
    check("R5", "right write blocked while busy", rightMemWrN, 1'b1);
    // end the match by moving left away
    leftAddr = 14'h0007;
    #1;
    check("R7", "rightBusy still low before edge", rightBusyOutN, 1'b0);
    tick();
    check("R7", "rightBusy released after edge", rightBusyOutN, 1'b1);
    check("R8", "right write passes after release", rightMemWrN, 1'b0);
    idle();
  endtask

  task automatic testLeftLater();
    leftCeN = 0; rightCeN = 0; leftAddr = 14'h3FF0; rightAddr = 14'h3FFE;
    tick();
    leftAddr = 14'h3FFE; leftWrN = 0;
    #1;
    check("R5", "left write blocked same cycle", leftMemWrN, 1'b1);
    tick();
    check("R2", "leftBusy low (left later)", leftBusyOutN, 1'b0);
    check("R2", "rightBusy high (right earlier)", rightBusyOutN, 1'b1);
    check("R4", "not both busy", leftBusyOutN | rightBusyOutN, 1'b1);
    rightCeN = 1;
    tick();
    check("R7", "leftBusy released on enable high", leftBusyOutN, 1'b1);
    idle();
  endtask

  task automatic testTie();
    leftCeN = 0; rightCeN = 0; leftAddr = 14'h0010; rightAddr = 14'h0020;
    tick();
    leftAddr = 14'h0030; rightAddr = 14'h0030; leftWrN = 0; rightWrN = 0;
    #1;
    check("R3", "tie right write blocked", rightMemWrN, 1'b1);
    check("R3", "tie left write passes", leftMemWrN, 1'b0);
    tick();
    check("R3", "tie rightBusy low", rightBusyOutN, 1'b0);
    check("R3", "tie leftBusy high", leftBusyOutN, 1'b1);
    check("R4", "tie not both busy", leftBusyOutN | rightBusyOutN, 1'b1);
    idle();
  endtask

  task automatic testSlave();
    masterMode = 0;
    leftCeN = 0; rightCeN = 0; leftAddr = 14'h0040; rightAddr = 14'h0041;
    tick();
    rightAddr = 14'h0040; leftWrN = 0; rightWrN = 0;
    #1;
    check("R6", "slave right write not self-blocked", rightMemWrN, 1'b0);
    tick();
    check("R6", "slave rightBusy high", rightBusyOutN, 1'b1);
    check("R6", "slave leftBusy high", leftBusyOutN, 1'b1);
    leftBusyInN = 0;
    #1;
    check("R6", "slave left write inhibited by input", leftMemWrN, 1'b1);
    check("R6", "slave right write unaffected", rightMemWrN, 1'b0);
    idle();
    masterMode = 1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testNoMatch();
    testRightLater();
    testLeftLater();
    testTie();
    testSlave();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule